// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

The block is the central controller of a dynamically scheduled pipeline. Several functional units share one register file. Decoded instructions arrive one at a time. Each one names a target functional unit, a destination register and two source registers. The controller does three things:

- It decides when an instruction may enter a unit.
- It tells each unit when its operands may be read and execution may start.
- It grants the single register-file write port to one finished unit per cycle.

Instructions therefore start and finish out of order, while every data hazard is respected. Each functional unit is modelled by a latency counter with a fixed latency per unit. Unit number u takes BASE_LAT + (u-1)*LAT_STEP cycles, so the defaults give 2, 4, 6 and 8 cycles.

The controller keeps three kinds of state:

- The stage of the instruction held by each unit: idle, waiting for operands, executing, or waiting to write.
- A status entry per unit. It holds the destination, the two sources, the unit producing each source (0 meaning none), and a ready flag per source.
- A per-register table naming the unit that will write that register, where 0 means no writer is pending.

Write-after-write hazards are resolved by holding issue. Write-after-read hazards are resolved by holding writeback. Nothing is renamed or forwarded.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset all units are idle and no register has a pending writer. read_o, exec_done_o, wb_valid_o and war_hold_o are 0, and wb_fu_o and wb_reg_o read 0.
- R2: issue_o is high in the same cycle that instr_valid_i is high, the named unit is free, and no pending writer exists for the destination. The unit number must be in the range 1..NUM_FU. stall_struct_o is high when the request is valid and the unit is busy or its number is 0 or greater than NUM_FU. stall_waw_o is high when the request is valid and the destination has a pending writer. The two stall flags are independent, and issue_o is low whenever either is high.
- R3: An issued unit reads its operands (read_o bit u-1 is high for one cycle) in the first cycle, at least one cycle after issue, in which both sources are ready. A source is ready at issue if its register has no pending writer, or if its producer is granted writeback in the issue cycle. Otherwise it becomes ready in the cycle after its producer's writeback grant. Several units may read in the same cycle.
- R4: exec_done_o bit u-1 pulses exactly LAT(u) cycles after that unit's read pulse, where LAT(u) = BASE_LAT + (u-1)*LAT_STEP.
- R5: A unit becomes eligible to write in the cycle after its done pulse, and stays eligible until it is granted.
- R6: An eligible unit is held while any unit that is still waiting to read lists the eligible unit's destination as a source whose ready flag is set. war_hold_o is high in every cycle in which at least one eligible unit is held this way.
- R7: At most one unit is granted per cycle: the lowest-numbered unit that is eligible and not held. wb_valid_o is then 1, wb_fu_o carries the unit number and wb_reg_o carries its destination. With no grant, all three read 0.
- R8: A grant frees its unit and clears the pending writer of its register. From the next cycle an issue to that unit is not structurally stalled, and a new write to that register is not write-after-write stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | A decoded instruction is presented |
| instr_fu_i | input | FUW | Target unit number, 1..NUM_FU |
| instr_dst_i | input | RW | Destination register |
| instr_src1_i | input | RW | First source register |
| instr_src2_i | input | RW | Second source register |
| issue_o | output | 1 | Instruction accepted this cycle |
| stall_struct_o | output | 1 | Held: unit busy or not present |
| stall_waw_o | output | 1 | Held: destination already has a pending writer |
| read_o | output | NUM_FU | Per unit: read operands and start now |
| exec_done_o | output | NUM_FU | Per unit: execution finished |
| war_hold_o | output | 1 | A finished unit is held by a write-after-read hazard |
| wb_valid_o | output | 1 | Register-file write granted this cycle |
| wb_fu_o | output | FUW | Unit number of the granted unit |
| wb_reg_o | output | RW | Register written by the granted unit |

## Verification
The assertions assume that the instruction source keeps a valid instruction steady until issue_o accepts it, so that no later instruction overtakes a stalled one. They also assume that register numbers stay inside the table, which holds because NUM_REGS is a power of two. The bench generates its stream in that discipline. It holds every instruction that names a real unit until it is accepted, and it withdraws an instruction naming a missing unit after one cycle. Random traffic is aimed at a narrow set of registers so that structural, write-after-write and write-after-read stalls, and grants in the same cycle as an issue, occur often.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPS  = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } stage_e;
endpackage

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(LAT);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  AST_TMR_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0); // R4
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry import sb_pkg::*; #(
  parameter int FUW = 3,
  parameter int RW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [RW-1:0]  dst_i,
  input  logic [RW-1:0]  src1_i,
  input  logic [RW-1:0]  src2_i,
  input  logic [FUW-1:0] qj_i,
  input  logic [FUW-1:0] qk_i,
  input  logic           bcast_i,
  input  logic [FUW-1:0] bcast_fu_i,
  input  logic           done_i,
  input  logic           gnt_i,
  output stage_e         stage_o,
  output logic [RW-1:0]  fi_o,
  output logic [RW-1:0]  fj_o,
  output logic [RW-1:0]  fk_o,
  output logic           rj_o,
  output logic           rk_o,
  output logic           read_o
);
  stage_e         stage_q;
  logic [FUW-1:0] qj_q, qk_q;

  assign stage_o = stage_q;
  assign read_o  = (stage_q == ST_OPS) && rj_o && rk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      fi_o <= '0; fj_o <= '0; fk_o <= '0;
      qj_q <= '0; qk_q <= '0;
      rj_o <= 1'b0; rk_o <= 1'b0;
    end else if (load_i) begin
      stage_q <= ST_OPS;
      fi_o <= dst_i; fj_o <= src1_i; fk_o <= src2_i;
      qj_q <= qj_i;  qk_q <= qk_i;
      rj_o <= (qj_i == '0);
      rk_o <= (qk_i == '0);
    end else begin
      unique case (stage_q)
        ST_OPS: begin
          if (read_o) begin
            rj_o <= 1'b0; rk_o <= 1'b0;
            stage_q <= ST_EXEC;
          end else begin
            // producer broadcast: mark source ready and forget producer
            if (bcast_i && !rj_o && qj_q == bcast_fu_i) begin
              rj_o <= 1'b1; qj_q <= '0;
            end
            if (bcast_i && !rk_o && qk_q == bcast_fu_i) begin
              rk_o <= 1'b1; qk_q <= '0;
            end
          end
        end
        ST_EXEC: if (done_i) stage_q <= ST_WB;
        ST_WB:   if (gnt_i)  stage_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> stage_q == ST_IDLE); // R2
  AST_DONE_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> stage_q == ST_EXEC); // R4
  AST_GNT_IN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> stage_q == ST_WB); // R7
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N  = 4,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          valid_o,
  output logic [IW-1:0] fu_o
);
  always_comb begin
    gnt_o   = '0;
    valid_o = 1'b0;
    fu_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !valid_o) begin
        gnt_o[i] = 1'b1;
        valid_o  = 1'b1;
        fu_o     = IW'(i + 1);
      end
    end
  end

  AST_ARB_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R7
  AST_ARB_GRANT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R7
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl import sb_pkg::*; #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  parameter int BASE_LAT = 2,
  parameter int LAT_STEP = 2,
  localparam int FUW = $clog2(NUM_FU + 1),
  localparam int RW  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [FUW-1:0]    instr_fu_i,
  input  logic [RW-1:0]     instr_dst_i,
  input  logic [RW-1:0]     instr_src1_i,
  input  logic [RW-1:0]     instr_src2_i,
  output logic              issue_o,
  output logic              stall_struct_o,
  output logic              stall_waw_o,
  output logic [NUM_FU-1:0] read_o,
  output logic [NUM_FU-1:0] exec_done_o,
  output logic              war_hold_o,
  output logic              wb_valid_o,
  output logic [FUW-1:0]    wb_fu_o,
  output logic [RW-1:0]     wb_reg_o
);
  stage_e            stage [NUM_FU];
  logic [RW-1:0]     fi [NUM_FU];
  logic [RW-1:0]     fj [NUM_FU];
  logic [RW-1:0]     fk [NUM_FU];
  logic [NUM_FU-1:0] rj_v, rk_v, busy_v, load_v, wb_elig, war_blk, wb_req, wb_gnt;
  logic [FUW-1:0]    res_q [NUM_REGS];
  logic [FUW-1:0]    qj_in, qk_in;
  logic              fu_hit, fu_busy, dst_pend;

  // issue decision
  always_comb begin
    fu_hit  = 1'b0;
    fu_busy = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (instr_fu_i == FUW'(u + 1)) begin
        fu_hit  = 1'b1;
        fu_busy = busy_v[u];
      end
    end
  end

  assign dst_pend       = (res_q[instr_dst_i] != '0);
  assign stall_struct_o = instr_valid_i && (!fu_hit || fu_busy);
  assign stall_waw_o    = instr_valid_i && dst_pend;
  assign issue_o        = instr_valid_i && fu_hit && !fu_busy && !dst_pend;

  // a producer writing back in the issue cycle counts as already done
  always_comb begin
    qj_in = res_q[instr_src1_i];
    qk_in = res_q[instr_src2_i];
    if (wb_valid_o && qj_in == wb_fu_o) qj_in = '0;
    if (wb_valid_o && qk_in == wb_fu_o) qk_in = '0;
  end

  // per-unit status and latency model
  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    localparam int LAT_U = BASE_LAT + u * LAT_STEP;

    assign load_v[u]  = issue_o && (instr_fu_i == FUW'(u + 1));
    assign busy_v[u]  = (stage[u] != ST_IDLE);
    assign wb_elig[u] = (stage[u] == ST_WB);
    assign wb_req[u]  = wb_elig[u] && !war_blk[u];

    sb_fu_entry #(.FUW(FUW), .RW(RW)) i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_v[u]),
      .dst_i      (instr_dst_i),
      .src1_i     (instr_src1_i),
      .src2_i     (instr_src2_i),
      .qj_i       (qj_in),
      .qk_i       (qk_in),
      .bcast_i    (wb_valid_o),
      .bcast_fu_i (wb_fu_o),
      .done_i     (exec_done_o[u]),
      .gnt_i      (wb_gnt[u]),
      .stage_o    (stage[u]),
      .fi_o       (fi[u]),
      .fj_o       (fj[u]),
      .fk_o       (fk[u]),
      .rj_o       (rj_v[u]),
      .rk_o       (rk_v[u]),
      .read_o     (read_o[u])
    );

    sb_fu_timer #(.LAT(LAT_U)) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (read_o[u]),
      .done_o  (exec_done_o[u])
    );
  end

  // write-after-read hold: an unread ready source still names our destination
  always_comb begin
    war_blk = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      for (int f = 0; f < NUM_FU; f++) begin
        if (stage[f] == ST_OPS &&
            ((fj[f] == fi[u] && rj_v[f]) || (fk[f] == fi[u] && rk_v[f])))
          war_blk[u] = 1'b1;
      end
    end
  end

  assign war_hold_o = |(wb_elig & war_blk);

  sb_wb_arbiter #(.N(NUM_FU), .IW(FUW)) i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (wb_req),
    .gnt_o   (wb_gnt),
    .valid_o (wb_valid_o),
    .fu_o    (wb_fu_o)
  );

  always_comb begin
    wb_reg_o = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (wb_gnt[u]) wb_reg_o = fi[u];
  end

  // register result table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) res_q[r] <= '0;
    end else begin
      if (wb_valid_o) res_q[wb_reg_o]    <= '0;
      if (issue_o)    res_q[instr_dst_i] <= instr_fu_i;
    end
  end

  AST_WB_OWNS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> res_q[wb_reg_o] == wb_fu_o); // R5
  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_v)); // R2
endmodule

// File: tb/test_scoreboard_ctrl.sv
module test_scoreboard_ctrl;
  localparam int NF = 4;
  localparam int NR = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       instr_valid_i = 1'b0;
  logic [2:0] instr_fu_i = '0;
  logic [3:0] instr_dst_i = '0, instr_src1_i = '0, instr_src2_i = '0;
  logic       issue_o, stall_struct_o, stall_waw_o, war_hold_o, wb_valid_o;
  logic [NF-1:0] read_o, exec_done_o;
  logic [2:0] wb_fu_o;
  logic [3:0] wb_reg_o;

  always #5 clk = ~clk;

  scoreboard_ctrl i_scoreboard_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .instr_fu_i(instr_fu_i), .instr_dst_i(instr_dst_i),
    .instr_src1_i(instr_src1_i), .instr_src2_i(instr_src2_i),
    .issue_o(issue_o), .stall_struct_o(stall_struct_o), .stall_waw_o(stall_waw_o),
    .read_o(read_o), .exec_done_o(exec_done_o), .war_hold_o(war_hold_o),
    .wb_valid_o(wb_valid_o), .wb_fu_o(wb_fu_o), .wb_reg_o(wb_reg_o)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // model state: stage 0 idle, 1 wait operands, 2 exec, 3 wait write
  int m_stage[NF], m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF], m_cnt[NF];
  bit m_rj[NF], m_rk[NF];
  int m_res[NR];

  bit e_issue, e_struct, e_waw, e_war, e_wbv;
  int e_wbfu, e_wbreg;
  bit [NF-1:0] e_read, e_done, e_gnt;

  bit cur_v; int cur_fu, cur_d, cur_s1, cur_s2;
  int saw_war = 0, saw_waw = 0, saw_struct = 0;

  function automatic int lat_of(int u); return 2 + 2 * u; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic eval();
    bit hit, busy, pend, blk;
    hit = (cur_fu >= 1 && cur_fu <= NF);
    busy = hit ? (m_stage[cur_fu-1] != 0) : 1'b0;
    pend = (m_res[cur_d] != 0);
    e_struct = cur_v && (!hit || busy);
    e_waw = cur_v && pend;
    e_issue = cur_v && !e_struct && !e_waw;
    e_war = 0; e_wbv = 0; e_wbfu = 0; e_wbreg = 0; e_gnt = '0;
    for (int u = 0; u < NF; u++) begin
      e_read[u] = (m_stage[u] == 1) && m_rj[u] && m_rk[u];
      e_done[u] = (m_stage[u] == 2) && (m_cnt[u] == 1);
      blk = 0;
      for (int f = 0; f < NF; f++)
        if (m_stage[f] == 1 && ((m_fj[f] == m_fi[u] && m_rj[f]) || (m_fk[f] == m_fi[u] && m_rk[f])))
          blk = 1;
      if (m_stage[u] == 3 && blk) e_war = 1;
      if (m_stage[u] == 3 && !blk && !e_wbv) begin
        e_wbv = 1; e_wbfu = u + 1; e_wbreg = m_fi[u]; e_gnt[u] = 1;
      end
    end
  endtask

  task automatic update();
    int qj, qk;
    for (int u = 0; u < NF; u++) begin
      if (e_issue && cur_fu == u + 1) begin
        qj = m_res[cur_s1]; qk = m_res[cur_s2];
        if (e_wbv && qj == e_wbfu) qj = 0;
        if (e_wbv && qk == e_wbfu) qk = 0;
        m_stage[u] = 1; m_fi[u] = cur_d; m_fj[u] = cur_s1; m_fk[u] = cur_s2;
        m_qj[u] = qj; m_qk[u] = qk; m_rj[u] = (qj == 0); m_rk[u] = (qk == 0);
      end else if (m_stage[u] == 1) begin
        if (e_read[u]) begin
          m_rj[u] = 0; m_rk[u] = 0; m_stage[u] = 2; m_cnt[u] = lat_of(u);
        end else begin
          if (e_wbv && !m_rj[u] && m_qj[u] == e_wbfu) begin m_rj[u] = 1; m_qj[u] = 0; end
          if (e_wbv && !m_rk[u] && m_qk[u] == e_wbfu) begin m_rk[u] = 1; m_qk[u] = 0; end
        end
      end else if (m_stage[u] == 2) begin
        if (e_done[u]) m_stage[u] = 3;
        m_cnt[u]--;
      end else if (m_stage[u] == 3) begin
        if (e_gnt[u]) m_stage[u] = 0;
      end
    end
    if (e_wbv) m_res[e_wbreg] = 0;
    if (e_issue) m_res[cur_d] = cur_fu;
  endtask

  task automatic compare();
    chk("R2 R8 issue_o", int'(issue_o), int'(e_issue));
    chk("R2 R8 stall_struct_o", int'(stall_struct_o), int'(e_struct));
    chk("R2 R8 stall_waw_o", int'(stall_waw_o), int'(e_waw));
    chk("R3 read_o", int'(read_o), int'(e_read));
    chk("R4 exec_done_o", int'(exec_done_o), int'(e_done));
    chk("R6 war_hold_o", int'(war_hold_o), int'(e_war));
    chk("R5 R7 wb_valid_o", int'(wb_valid_o), int'(e_wbv));
    chk("R5 R7 wb_fu_o", int'(wb_fu_o), e_wbfu);
    chk("R7 wb_reg_o", int'(wb_reg_o), e_wbreg);
    if (war_hold_o) saw_war++;
    if (stall_waw_o) saw_waw++;
    if (stall_struct_o) saw_struct++;
  endtask

  // directed stream: long producer, dependent reader, write-after-read,
  // write-after-write, structural, missing unit
  int dfu[7] = '{3, 1, 2, 4, 1, 0, 2};
  int ddst[7] = '{1, 4, 5, 4, 9, 3, 1};
  int ds1[7] = '{2, 1, 6, 7, 4, 3, 4};
  int ds2[7] = '{3, 5, 6, 7, 4, 3, 9};
  int didx = 0;
  bit rand_on = 0;

  task automatic next_instr();
    if (cur_v && (e_issue || cur_fu < 1 || cur_fu > NF)) cur_v = 0;
    if (!cur_v) begin
      if (didx < 7) begin
        cur_v = 1; cur_fu = dfu[didx]; cur_d = ddst[didx];
        cur_s1 = ds1[didx]; cur_s2 = ds2[didx]; didx++;
      end else if (rand_on && ($urandom % 10) < 7) begin
        cur_v = 1;
        cur_fu = (($urandom % 12) == 0) ? 0 : 1 + int'($urandom % NF);
        cur_d = int'($urandom % 6);
        cur_s1 = int'($urandom % 6);
        cur_s2 = (($urandom % 4) == 0) ? int'($urandom % NR) : int'($urandom % 6);
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    instr_valid_i = cur_v;
    instr_fu_i = 3'(cur_fu); instr_dst_i = 4'(cur_d);
    instr_src1_i = 4'(cur_s1); instr_src2_i = 4'(cur_s2);
    #2;
    eval();
    compare();
    update();
    next_instr();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R3 act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    for (int u = 0; u < NF; u++) begin
      m_stage[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
      m_qj[u] = 0; m_qk[u] = 0; m_cnt[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
    end
    for (int r = 0; r < NR; r++) m_res[r] = 0;
    cur_v = 0; cur_fu = 0; cur_d = 0; cur_s1 = 0; cur_s2 = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset read_o", int'(read_o), 0);
    chk("R1 reset wb_valid_o", int'(wb_valid_o), 0);
    chk("R1 reset wb_fu_o", int'(wb_fu_o), 0);
    chk("R1 reset war_hold_o", int'(war_hold_o), 0);
    chk("R1 reset exec_done_o", int'(exec_done_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    next_instr();
    repeat (120) cycle();
    chk("R6 write-after-read hold observed", int'(saw_war > 0), 1);
    chk("R2 write-after-write stall observed", int'(saw_waw > 0), 1);
    chk("R2 structural stall observed", int'(saw_struct > 0), 1);
    rand_on = 1;
    repeat (4000) cycle();
    rand_on = 0;
    repeat (200) cycle();
    chk("R8 drained idle wb_valid_o", int'(wb_valid_o), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule